// File: doc/BRIEF.md
# Multi-Bus Memory Grant Arbiter

This block decides, every clock cycle, which processors may use a small pool of shared buses to reach an interleaved memory. Each processor offers a request flag and the index of the memory bank it wants. The arbiter picks a set of requests that fits two limits at once. First, no more requests than there are working buses. Second, no bank is served twice in the same cycle. Each winner is told which bus it was given. A per-bus health mask takes broken buses out of the pool, and the remaining buses keep carrying traffic.

Each processor's request works as a stream handshake. `req_valid[i]` is the valid signal. The registered grant `gnt[i]`, which appears one cycle after the request was sampled, is the acceptance. A processor with no grant must keep `req_valid[i]` high and `req_bank` unchanged, and it is arbitrated again on the next edge. Once it sees the grant, it removes the request before the following edge (or presents a new one). A rotating priority pointer gives every processor a fair turn. The bus health mask is a plain control input and may change on any cycle.

Top module: `mbus_arbiter`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after release, `gnt` and `gnt_bus` are all zero, and the priority pointer starts at processor 0.
- R2: `gnt[i]` is high in the cycle after an edge only if `req_valid[i]` was high at that edge. A cycle with no requests produces no grants.
- R3: Among the grants issued for one edge, no two processors have the same 3-bit bank index (`req_bank[3*i+2:3*i]`).
- R4: The number of grants for one edge never exceeds the number of bus bits set in `bus_ok` at that edge. When more requests are eligible than buses are healthy, only the first ones in priority order win.
- R5: Bus indices are handed out in ascending order, skipping buses whose `bus_ok` bit is 0. The k-th grant in priority order gets the k-th healthy bus, so granted bus indices are distinct and healthy.
- R6: Processors are scanned starting from the priority pointer and wrapping from 7 to 0. A request wins if its bank is still unclaimed and a healthy bus remains. After an edge with at least one grant, the pointer moves to the processor after the last one granted in scan order.
- R7: When `bus_ok` is all zero, no grant is issued and the priority pointer does not move.
- R8: For any processor without a grant, its 2-bit field in `gnt_bus` (`gnt_bus[2*i+1:2*i]`) reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 8 | Per-processor request valid |
| req_bank | input | 24 | Per-processor target bank, 3 bits each, processor i at bits 3*i+2:3*i |
| bus_ok | input | 4 | Per-bus health mask, 1 means usable |
| gnt | output | 8 | Registered per-processor grant |
| gnt_bus | output | 8 | Registered granted bus index, 2 bits per processor at bits 2*i+1:2*i |

## Verification
The bench builds the block with its default shape of eight processors, four buses and eight banks. With this shape, demand can exceed the bus pool by a factor of two. Bank collisions are frequent under random traffic, and the pointer wraps around within a few busy cycles. Partial health masks such as 1010, and the all-failed mask, put bus skipping and the zero-capacity case within reach. Long runs with held requests then show that requests which lost to bank conflicts or bus shortage are served in later cycles.

// File: rtl/mba_pkg.sv
package mba_pkg;
  // Default shape of the arbiter
  localparam int DEF_PROCS = 8;
  localparam int DEF_BUSES = 4;
  localparam int DEF_BANKS = 8;

  // Width of an index into a set of n items (at least one bit)
  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // Width of a counter that must reach n
  function automatic int cnt_w(input int n);
    return $clog2(n + 1);
  endfunction
endpackage

// File: rtl/mba_bus_pool.sv
// Compacts the healthy buses into an ascending list and counts them.
module mba_bus_pool #(
  parameter int NB = mba_pkg::DEF_BUSES,
  localparam int BUS_W = mba_pkg::idx_w(NB),
  localparam int CNT_W = mba_pkg::cnt_w(NB)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NB-1:0]              ok_i,
  output logic [NB-1:0][BUS_W-1:0]   slot_o,
  output logic [CNT_W-1:0]           n_ok_o
);
  logic [CNT_W-1:0] k;

  always_comb begin
    slot_o = '0;
    k      = '0;
    for (int b = 0; b < NB; b++) begin
      if (ok_i[b]) begin
        slot_o[k[BUS_W-1:0]] = BUS_W'(b);
        k = k + CNT_W'(1);
      end
    end
    n_ok_o = k;
  end

  // R5: the first list slot is the lowest healthy bus
  assert_first_slot_healthy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (n_ok_o != '0) |-> ok_i[slot_o[0]]);

  // R4: the count of usable buses equals the population of the mask
  assert_pool_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
    int'(n_ok_o) == $countones(ok_i));
endmodule

// File: rtl/mba_scan.sv
// One rotating pass over the processors, claiming banks and buses.
module mba_scan #(
  parameter int NP = mba_pkg::DEF_PROCS,
  parameter int NB = mba_pkg::DEF_BUSES,
  parameter int NM = mba_pkg::DEF_BANKS,
  localparam int PROC_W = mba_pkg::idx_w(NP),
  localparam int BUS_W  = mba_pkg::idx_w(NB),
  localparam int BANK_W = mba_pkg::idx_w(NM),
  localparam int CNT_W  = mba_pkg::cnt_w(NB)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NP-1:0]              req_i,
  input  logic [NP*BANK_W-1:0]       bank_i,
  input  logic [PROC_W-1:0]          ptr_i,
  input  logic [NB-1:0][BUS_W-1:0]   slot_i,
  input  logic [CNT_W-1:0]           n_ok_i,
  output logic [NP-1:0]              gnt_o,
  output logic [NP*BUS_W-1:0]        bus_o,
  output logic                       any_o,
  output logic [PROC_W-1:0]          last_o
);
  logic [BANK_W-1:0] bank_arr [NP];
  logic [BUS_W-1:0]  bus_arr  [NP];

  for (genvar g = 0; g < NP; g++) begin : g_unpack
    assign bank_arr[g] = bank_i[g*BANK_W +: BANK_W];
    assign bus_o[g*BUS_W +: BUS_W] = bus_arr[g];
  end

  logic [NM-1:0]     claimed;
  logic [CNT_W-1:0]  used;
  logic [PROC_W-1:0] p;
  logic [BANK_W-1:0] bk;

  always_comb begin
    gnt_o   = '0;
    any_o   = 1'b0;
    last_o  = '0;
    claimed = '0;
    used    = '0;
    p       = '0;
    bk      = '0;
    for (int q = 0; q < NP; q++) bus_arr[q] = '0;
    for (int i = 0; i < NP; i++) begin
      p  = PROC_W'((int'(ptr_i) + i) % NP);
      bk = bank_arr[p];
      if (req_i[p] && !claimed[bk] && (used < n_ok_i)) begin
        gnt_o[p]   = 1'b1;
        bus_arr[p] = slot_i[used[BUS_W-1:0]];
        claimed[bk] = 1'b1;
        used   = used + CNT_W'(1);
        any_o  = 1'b1;
        last_o = p;
      end
    end
  end

  // R4: grants of one pass never exceed the usable bus count
  assert_scan_limit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(gnt_o) <= int'(n_ok_i));

  // R2: a pass only picks requesting processors
  assert_scan_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_o & ~req_i) == '0);

  // R6: the reported last winner is itself a winner
  assert_last_granted_R6: assert property (@(posedge clk) disable iff (!rst_n)
    any_o |-> gnt_o[last_o]);
endmodule

// File: rtl/mba_rr_ptr.sv
// Rotating priority pointer.
module mba_rr_ptr #(
  parameter int NP = mba_pkg::DEF_PROCS,
  localparam int PROC_W = mba_pkg::idx_w(NP)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              any_i,
  input  logic [PROC_W-1:0] last_i,
  output logic [PROC_W-1:0] ptr_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_o <= '0;
    end else if (any_i) begin
      ptr_o <= (last_i == PROC_W'(NP - 1)) ? '0 : last_i + PROC_W'(1);
    end
  end

  // R6: the pointer rests when nothing was granted
  assert_ptr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !any_i |=> $stable(ptr_o));

  // R6: the pointer always names a real processor
  assert_ptr_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    int'(ptr_o) < NP);
endmodule

// File: rtl/mbus_arbiter.sv
// Top: bus pool, rotating scan, pointer and registered grants.
module mbus_arbiter #(
  parameter int NPROC = mba_pkg::DEF_PROCS,
  parameter int NBUS  = mba_pkg::DEF_BUSES,
  parameter int NBANK = mba_pkg::DEF_BANKS,
  localparam int PROC_W = mba_pkg::idx_w(NPROC),
  localparam int BUS_W  = mba_pkg::idx_w(NBUS),
  localparam int BANK_W = mba_pkg::idx_w(NBANK),
  localparam int CNT_W  = mba_pkg::cnt_w(NBUS)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NPROC-1:0]          req_valid,
  input  logic [NPROC*BANK_W-1:0]   req_bank,
  input  logic [NBUS-1:0]           bus_ok,
  output logic [NPROC-1:0]          gnt,
  output logic [NPROC*BUS_W-1:0]    gnt_bus
);
  logic [NBUS-1:0][BUS_W-1:0] slot;
  logic [CNT_W-1:0]           n_ok;
  logic [PROC_W-1:0]          ptr;
  logic [NPROC-1:0]           gnt_d;
  logic [NPROC*BUS_W-1:0]     bus_d;
  logic                       any_d;
  logic [PROC_W-1:0]          last_d;

  mba_bus_pool #(.NB(NBUS)) u_pool (
    .clk(clk), .rst_n(rst_n), .ok_i(bus_ok), .slot_o(slot), .n_ok_o(n_ok)
  );

  mba_scan #(.NP(NPROC), .NB(NBUS), .NM(NBANK)) u_scan (
    .clk(clk), .rst_n(rst_n),
    .req_i(req_valid), .bank_i(req_bank), .ptr_i(ptr),
    .slot_i(slot), .n_ok_i(n_ok),
    .gnt_o(gnt_d), .bus_o(bus_d), .any_o(any_d), .last_o(last_d)
  );

  mba_rr_ptr #(.NP(NPROC)) u_ptr (
    .clk(clk), .rst_n(rst_n), .any_i(any_d), .last_i(last_d), .ptr_o(ptr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gnt     <= '0;
      gnt_bus <= '0;
    end else begin
      gnt     <= gnt_d;
      gnt_bus <= bus_d;
    end
  end

  // R4: never more grants than healthy buses at the sampling edge
  assert_bus_limit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $countones(gnt) <= $countones($past(bus_ok)));

  // R7: an empty bus pool yields no grants
  assert_all_failed_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_ok == '0) |=> (gnt == '0));

  for (genvar i = 0; i < NPROC; i++) begin : g_chk
    // R2: a grant follows a sampled request
    assert_grant_had_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid[i] == 1'b0 |=> !gnt[i]);

    // R5: the granted bus was healthy when sampled
    assert_bus_healthy_R5: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (!gnt[i] || ((NBUS'(1) << gnt_bus[i*BUS_W +: BUS_W]) & $past(bus_ok)) != '0));

    // R8: idle processors show bus index zero
    assert_idle_bus_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !gnt[i] |-> gnt_bus[i*BUS_W +: BUS_W] == '0);

    for (genvar j = i + 1; j < NPROC; j++) begin : g_pair
      // R3: two winners of one edge never share a bank
      assert_bank_once_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_bank[i*BANK_W +: BANK_W] == req_bank[j*BANK_W +: BANK_W]) |=> !(gnt[i] && gnt[j]));

      // R5: two winners never share a bus
      assert_bus_distinct_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt[i] && gnt[j]) |-> gnt_bus[i*BUS_W +: BUS_W] != gnt_bus[j*BUS_W +: BUS_W]);
    end
  end
endmodule

// File: tb/mbus_arbiter_tb_top.sv
`timescale 1ns/1ps
module mbus_arbiter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  req = '0;
  logic [23:0] bank = '0;
  logic [3:0]  ok = 4'hF;
  logic [7:0]  gnt;
  logic [15:0] gnt_bus;

  int checks = 0;
  int fails = 0;
  int mptr = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  mbus_arbiter dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req), .req_bank(bank),
    .bus_ok(ok), .gnt(gnt), .gnt_bus(gnt_bus)
  );

  // Reference grant computation from the requirements
  task automatic model(input logic [7:0] rv, input logic [23:0] rb, input logic [3:0] mk,
                       input int ptr, output logic [7:0] eg, output logic [15:0] eb,
                       output int nptr);
    int healthy[4];
    int nh = 0;
    int used = 0;
    bit taken[8];
    eg = '0; eb = '0; nptr = ptr;
    for (int b = 0; b < 4; b++) if (mk[b]) begin healthy[nh] = b; nh++; end
    for (int k = 0; k < 8; k++) taken[k] = 0;
    for (int i = 0; i < 8; i++) begin
      int p = (ptr + i) % 8;
      int bk = int'(rb[p*3 +: 3]);
      if (rv[p] && !taken[bk] && used < nh) begin
        eg[p] = 1'b1;
        eb[p*2 +: 2] = 2'(healthy[used]);
        taken[bk] = 1;
        used++;
        nptr = (p + 1) % 8;
      end
    end
  endtask

  task automatic step(input string tag);
    logic [7:0] eg; logic [15:0] eb; int np;
    model(req, bank, ok, mptr, eg, eb, np);
    @(posedge clk); #1;
    checks++;
    if (gnt !== eg || gnt_bus !== eb) begin
      fails++;
      $display("FAIL %s: gnt=%h gnt_bus=%h expected gnt=%h gnt_bus=%h", tag, gnt, gnt_bus, eg, eb);
    end
    mptr = np;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog R2: run hung, actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (gnt !== 8'h00 || gnt_bus !== 16'h0) begin
      fails++;
      $display("FAIL R1: gnt=%h gnt_bus=%h expected gnt=00 gnt_bus=0000", gnt, gnt_bus);
    end
    rst_n = 1'b1;

    // R4 R5: eight distinct banks, four buses, pointer at 0
    req = 8'hFF; bank = {3'd7,3'd6,3'd5,3'd4,3'd3,3'd2,3'd1,3'd0};
    step("R4 R5 oversubscribed");
    step("R6 second half after rotation");
    // R3: every processor targets bank 2
    bank = {8{3'd2}};
    step("R3 single bank");
    // R5: buses 1 and 3 healthy only
    ok = 4'b1010; req = 8'b0000_0110; bank = {3'd7,3'd6,3'd5,3'd4,3'd3,3'd2,3'd1,3'd0};
    step("R5 skip failed buses");
    // R7: all buses failed, pointer must hold
    ok = 4'b0000; req = 8'hFF;
    step("R7 no healthy bus");
    step("R7 no healthy bus again");
    ok = 4'hF;
    step("R7 R6 pointer held after empty pool");
    // R2 R8: no requests, then a lone requester
    req = 8'h00;
    step("R2 R8 idle");
    req = 8'h20;
    step("R2 lone requester");
    req = 8'h00;

    // Random traffic with held requests
    for (int c = 0; c < 3000; c++) begin
      logic [7:0] eg; logic [15:0] eb; int np;
      for (int i = 0; i < 8; i++) begin
        if (!req[i] && ($urandom % 3 == 0)) begin
          req[i] = 1'b1;
          bank[i*3 +: 3] = 3'($urandom % 8);
        end
      end
      ok = ($urandom % 6 == 0) ? 4'($urandom) : 4'hF;
      model(req, bank, ok, mptr, eg, eb, np);
      step("R6 random traffic");
      req = req & ~eg;
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule